// File: doc/BRIEF.md
# Watchdog and Reset Sequencer

This block produces the processor reset for a chip that runs from a 32.768 kHz crystal clock. The reset has two sources. The first is an external active-high reset pin. The second is an independent watchdog that firmware must refresh within a fixed period.

After either source, the block holds the processor in reset for a fixed number of crystal cycles. It then releases the processor, which begins fetching at address 0x0000.

The block also tells the rest of the chip which source caused the reset:
- A reset from the pin asserts the register-clear enable, so the memory-mapped I/O registers return to their defaults.
- A reset from the watchdog leaves that enable low, so those registers keep their contents.
- A sticky cause flag records a watchdog reset, and it stays readable after launch.

Firmware cannot switch the watchdog off. It is stopped only by two pin conditions: the emulator-enable pin, or the indication that the power-fault comparator input is tied to the digital supply.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_pin` is 1, `cpu_rst` and `reg_clr` are 1 and `cause_wd` is 0. These values take effect at once, without waiting for a clock edge.
- R2: After `rst_pin` falls, `cpu_rst` stays 1 through the first RELEASE_CYCLES-1 rising edges of `clk_xtal` and goes to 0 at edge number RELEASE_CYCLES (default 4096). That edge is the launch at address 0x0000.
- R3: With the watchdog enabled and no refresh, `cpu_rst` rises at edge WD_CYCLES (default 49152) counted from the launch edge.
- R4: A refresh (`wd_kick` = 1 at an edge while running) clears the watchdog count. The next overflow then comes WD_CYCLES edges after that refresh edge.
- R5: A watchdog reset holds `cpu_rst` at 1 for RELEASE_CYCLES edges and then launches again. `reg_clr` stays 0 for the whole of that reset.
- R6: `cause_wd` becomes 1 at a watchdog overflow. It stays 1 through the launch and any later running, and only `rst_pin` clears it.
- R7: While `emu_en` is 1, the watchdog never overflows. Its count restarts from zero, so after `emu_en` falls the overflow comes WD_CYCLES edges later.
- R8: While `wd_pin_off` is 1, the watchdog never overflows, with the same restart-from-zero rule as R7.
- R9: Refresh strobes that arrive while reset is held are ignored. The overflow after the launch still comes exactly WD_CYCLES edges after the launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | 32.768 kHz crystal clock |
| rst_pin | input | 1 | External reset pin, active high, asynchronous assert |
| wd_kick | input | 1 | Watchdog refresh strobe from firmware |
| emu_en | input | 1 | Emulator-enable pin; 1 stops the watchdog |
| wd_pin_off | input | 1 | 1 when the comparator input is tied to the digital supply; stops the watchdog |
| cpu_rst | output | 1 | Processor reset, active high |
| reg_clr | output | 1 | Register-clear enable, 1 during a pin reset |
| cause_wd | output | 1 | Sticky flag, 1 when the last reset came from the watchdog |

## Verification
All three outputs come from registers, except that `rst_pin` sets them asynchronously.

| Result | When it is due |
|---|---|
| `cpu_rst` released | At the RELEASE_CYCLES-th rising edge after the pin falls |
| Watchdog overflow | At the WD_CYCLES-th edge after the launch edge, the last refresh edge, or the last edge at which a disable pin was high |
| `cause_wd` and `reg_clr` | Change at the same edge as `cpu_rst` |

The bench drives inputs and samples outputs 1 ns after a rising edge. It counts edges from the launch, and for each result checks the edge just before the one it is due on and the edge it is due on.

The bench uses short parameter values so that many overflows fit in one run.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

    typedef enum logic [0:0] {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       cause_wd;
    } seq_regs_t;

endpackage

// File: rtl/rstseq_count.sv
`timescale 1ns/1ps
// Up-counter with synchronous clear, asynchronous reset, and a terminal flag.
module rstseq_count #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic arst,
    input  logic clr,
    input  logic en,
    output logic at_last
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int RELEASE_CYCLES = 4096,
    parameter int WD_CYCLES      = 49152
) (
    input  logic clk_xtal,
    input  logic rst_pin,
    input  logic wd_kick,
    input  logic emu_en,
    input  logic wd_pin_off,
    output logic cpu_rst,
    output logic reg_clr,
    output logic cause_wd
);
    seq_regs_t r_d, r_q;

    logic holding, wd_active;
    logic rel_last, wd_last, wd_expire;

    assign holding   = (r_q.state == SEQ_HOLD);
    assign wd_active = !holding && !emu_en && !wd_pin_off;

    // Release delay: counts while held, cleared while running.
    rstseq_count #(.LIMIT(RELEASE_CYCLES)) u_release (
        .clk     (clk_xtal),
        .arst    (rst_pin),
        .clr     (!holding),
        .en      (holding),
        .at_last (rel_last)
    );

    // Watchdog: counts only while active; a refresh or any stop condition zeroes it.
    rstseq_count #(.LIMIT(WD_CYCLES)) u_wdog (
        .clk     (clk_xtal),
        .arst    (rst_pin),
        .clr     (!wd_active || wd_kick),
        .en      (1'b1),
        .at_last (wd_last)
    );

    assign wd_expire = wd_active && !wd_kick && wd_last;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_HOLD: if (rel_last) r_d.state = SEQ_RUN;
            SEQ_RUN: begin
                if (wd_expire) begin
                    r_d.state    = SEQ_HOLD;
                    r_d.cause_wd = 1'b1;
                end
            end
            default: r_d.state = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge clk_xtal or posedge rst_pin) begin
        if (rst_pin) begin
            r_q.state    <= SEQ_HOLD;
            r_q.cause_wd <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_rst  = holding;
    assign reg_clr  = holding && !r_q.cause_wd;
    assign cause_wd = r_q.cause_wd;
endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk (
    input logic clk_xtal,
    input logic rst_pin,
    input logic wd_kick,
    input logic emu_en,
    input logic wd_pin_off,
    input logic cpu_rst,
    input logic reg_clr,
    input logic cause_wd
);
    assert_pin_holds_R1: assert property (@(posedge clk_xtal)
        rst_pin |-> (cpu_rst && reg_clr && !cause_wd));

    assert_clr_inside_reset_R5: assert property (@(posedge clk_xtal) disable iff (rst_pin)
        reg_clr |-> cpu_rst);

    assert_wd_entry_keeps_regs_R5: assert property (@(posedge clk_xtal) disable iff (rst_pin)
        $rose(cpu_rst) |-> (cause_wd && !reg_clr));

    assert_cause_sticky_R6: assert property (@(posedge clk_xtal) disable iff (rst_pin)
        $past(cause_wd) |-> cause_wd);

    assert_kick_defers_R4: assert property (@(posedge clk_xtal) disable iff (rst_pin)
        (wd_kick && !cpu_rst) |=> !cpu_rst);

    assert_emu_blocks_R7: assert property (@(posedge clk_xtal) disable iff (rst_pin)
        (emu_en && !cpu_rst) |=> !cpu_rst);

    assert_pin_off_blocks_R8: assert property (@(posedge clk_xtal) disable iff (rst_pin)
        (wd_pin_off && !cpu_rst) |=> !cpu_rst);
endmodule

bind rstseq_top rstseq_chk u_chk (.*);

// File: tb/sim_rstseq_top.sv
`timescale 1ns/1ps
module sim_rstseq_top;
    localparam int REL = 16;
    localparam int WDP = 64;

    logic clk = 1'b0;
    logic rst_pin = 1'b1, wd_kick = 1'b0, emu_en = 1'b0, wd_pin_off = 1'b0;
    logic cpu_rst, reg_clr, cause_wd;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    rstseq_top #(.RELEASE_CYCLES(REL), .WD_CYCLES(WDP)) u0 (
        .clk_xtal(clk), .rst_pin(rst_pin), .wd_kick(wd_kick), .emu_en(emu_en),
        .wd_pin_off(wd_pin_off), .cpu_rst(cpu_rst), .reg_clr(reg_clr), .cause_wd(cause_wd)
    );

    typedef struct packed {
        logic [15:0] kick_at;  // edge after launch carrying a refresh, 0 = none
        logic [1:0]  dis;      // bit0 emu_en, bit1 wd_pin_off
        logic [15:0] t;        // edge after launch at which outputs are checked
    } case_t;

    localparam int NC = 10;
    localparam case_t CASES [NC] = '{
        '{16'd0,  2'd0, 16'd63},   // R3 one edge before overflow
        '{16'd0,  2'd0, 16'd64},   // R3 overflow edge
        '{16'd0,  2'd0, 16'd79},   // R5 still held
        '{16'd0,  2'd0, 16'd80},   // R5 relaunch, R6 cause kept
        '{16'd20, 2'd0, 16'd83},   // R4 before deferred overflow
        '{16'd20, 2'd0, 16'd84},   // R4 deferred overflow
        '{16'd1,  2'd0, 16'd65},   // R4 refresh at first edge
        '{16'd0,  2'd1, 16'd200},  // R7 emulator stops watchdog
        '{16'd0,  2'd2, 16'd200},  // R8 tied comparator stops watchdog
        '{16'd0,  2'd3, 16'd150}   // R7 R8 both stops
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pin_reset_and_launch();
        rst_pin = 1'b1;
        step(2);
        rst_pin = 1'b0;
        step(REL);
    endtask

    initial begin
        // R1 reset state before any edge
        #1;
        chk(cpu_rst, 1'b1, "R1 cpu_rst");
        chk(reg_clr, 1'b1, "R1 reg_clr");
        chk(cause_wd, 1'b0, "R1 cause_wd");

        // R2 release length
        step(2);
        rst_pin = 1'b0;
        step(REL - 1);
        chk(cpu_rst, 1'b1, "R2 held one edge before release");
        step(1);
        chk(cpu_rst, 1'b0, "R2 released");
        chk(reg_clr, 1'b0, "R2 reg_clr after launch");

        // Table-driven watchdog cases
        for (int i = 0; i < NC; i++) begin
            int fire;
            pin_reset_and_launch();
            chk(cpu_rst, 1'b0, "R2 launch");
            emu_en     = CASES[i].dis[0];
            wd_pin_off = CASES[i].dis[1];
            fire = (CASES[i].dis != 0) ? 1000000 :
                   (CASES[i].kick_at != 0) ? int'(CASES[i].kick_at) + WDP : WDP;
            for (int c = 1; c <= int'(CASES[i].t); c++) begin
                wd_kick = (c == int'(CASES[i].kick_at));
                step(1);
            end
            wd_kick = 1'b0;
            chk(cpu_rst, (int'(CASES[i].t) >= fire) && (int'(CASES[i].t) < fire + REL),
                $sformatf("R3/R4/R7/R8 case %0d cpu_rst", i));
            chk(cause_wd, int'(CASES[i].t) >= fire, $sformatf("R6 case %0d cause_wd", i));
            chk(reg_clr, 1'b0, $sformatf("R5 case %0d reg_clr", i));
            emu_en = 1'b0;
            wd_pin_off = 1'b0;
        end

        // R9 refreshes during hold are ignored
        rst_pin = 1'b1;
        step(2);
        rst_pin = 1'b0;
        wd_kick = 1'b1;
        step(REL);
        wd_kick = 1'b0;
        step(WDP - 1);
        chk(cpu_rst, 1'b0, "R9 before overflow");
        step(1);
        chk(cpu_rst, 1'b1, "R9 overflow at WD edge after launch");

        // R7 restart from zero after emulator pin drops
        pin_reset_and_launch();
        emu_en = 1'b1;
        step(100);
        emu_en = 1'b0;
        step(WDP - 1);
        chk(cpu_rst, 1'b0, "R7 before restarted overflow");
        step(1);
        chk(cpu_rst, 1'b1, "R7 restarted overflow");
        chk(reg_clr, 1'b0, "R5 reg_clr low in watchdog reset");

        // R5 hold length of a watchdog reset
        step(REL - 1);
        chk(cpu_rst, 1'b1, "R5 held before relaunch");
        step(1);
        chk(cpu_rst, 1'b0, "R5 relaunch");
        chk(cause_wd, 1'b1, "R6 cause after relaunch");

        // R6 only the pin clears the cause; R1 asynchronous effect
        rst_pin = 1'b1;
        #1;
        chk(cause_wd, 1'b0, "R6 pin clears cause");
        chk(reg_clr, 1'b1, "R1 reg_clr asynchronous");
        chk(cpu_rst, 1'b1, "R1 cpu_rst asynchronous");
        step(2);
        rst_pin = 1'b0;
        step(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL timeout: run did not end");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule